// File: doc/BRIEF.md
# Seconds Counter with Match Alarm

This block keeps time in whole seconds. A slow 32.768 kHz reference arrives on an external pin, asynchronous to the system clock. The block synchronises it and detects its rising edges, then divides the edges down to one count step per second. A 32-bit up counter holds the time of day. Software can load it, read it back and compare it against a programmed alarm value. When the counter steps onto the alarm value, a sticky status bit is set. That bit reaches the interrupt line only when the mask allows it.

The block has a small register port: one write strobe, an address, write data and a combinational read bus. A debug-halt input comes from the processor's debug logic. Two control bits select whether timekeeping carries on or pauses while the processor is halted. The block has no streaming data path. Every pin is a plain control or status signal, so no valid/ready handshake is involved and no back-pressure exists.

Top module: `sec_alarm_counter`

## Requirements
- R1: Each rising edge of `clk32_in` is seen once after a two-flop synchroniser. One count step occurs per 2^PRESC_W counted edges (32768 by default).
- R2: The first write of 1 to the enable bit after reset loads the counter with 1 at once. Every later enable resumes from the held value without reloading.
- R3: A write to LOAD (address 1) makes the next count step set the counter to the written value instead of incrementing it.
- R4: The counter counts up by one per step and wraps from 0xFFFFFFFF to 0. The wrap point is fixed.
- R5: A count step that lands the counter on MATCH (address 2) sets STATUS bit 0 (address 4). `irq` is high exactly when that bit and MASK bit 0 (address 3) are both 1.
- R6: Writing a 1 to bit 0 of CLEAR (address 5) clears the alarm status. Writing a 0 there leaves it unchanged.
- R7: Counting needs CTRL (address 0) bit 0 set. While the bit is clear, both the counter and the partial prescaler count hold their values.
- R8: While `dbg_halt` is high, counting continues if CTRL bit 2 is set. It freezes if bit 2 is clear and bit 1 is set. With both bits clear, `dbg_halt` has no effect.
- R9: After reset, all registers, the counter (read at VALUE, address 6), the status and `irq` are zero. CTRL, LOAD, MATCH and MASK read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk32_in | input | 1 | 32.768 kHz reference, asynchronous |
| dbg_halt | input | 1 | Processor halted by debugger |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Masked alarm interrupt |

## Verification
The assertions assume that `clk32_in` stays at each level for at least two system clocks, so that no edge is lost in the synchroniser. They also assume that `dbg_halt` and the register port are synchronous to `clk`. The stimulus holds the reference high and low for three clocks each and drives every port on the falling clock edge. It makes all observations when the prescaler is at a whole second, except in the prescaler-hold test, which deliberately stops partway through a second.

// File: rtl/sac_pkg.sv
package sac_pkg;
  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_LOAD  = 3'd1,
    A_MATCH = 3'd2,
    A_MASK  = 3'd3,
    A_STAT  = 3'd4,
    A_CLR   = 3'd5,
    A_VALUE = 3'd6
  } sac_addr_e;

  localparam int CTRL_W     = 3;
  localparam int B_EN       = 0;
  localparam int B_STALL    = 1;
  localparam int B_CONTINUE = 2;
endpackage

// File: rtl/sac_edge_sync.sv
module sac_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  localparam int DEPTH = STAGES + 1;
  logic [DEPTH-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[DEPTH-2:0], async_i};
  end

  assign rise_o = sh_q[DEPTH-2] & ~sh_q[DEPTH-1];
endmodule

// File: rtl/sac_prescaler.sv
module sac_prescaler #(
  parameter int W = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_i,
  input  logic run_i,
  output logic tick_o
);
  logic [W-1:0] div_q;
  logic         step;

  assign step = edge_i & run_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    div_q <= '0;
    else if (step) div_q <= div_q + 1'b1;
  end

  assign tick_o = step & (&div_q);
endmodule

// File: rtl/sac_count_core.sv
module sac_count_core #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          first_ld_i,
  input  logic          load_wr_i,
  input  logic [CW-1:0] load_val_i,
  input  logic [CW-1:0] match_i,
  input  logic          clr_i,
  output logic [CW-1:0] cnt_o,
  output logic          stat_o,
  output logic          pend_o
);
  logic [CW-1:0] cnt_q, nxt;
  logic          pend_q, stat_q;

  assign nxt = pend_q ? load_val_i : cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      if (first_ld_i)  cnt_q <= {{(CW-1){1'b0}}, 1'b1};
      else if (tick_i) cnt_q <= nxt;

      if (load_wr_i)   pend_q <= 1'b1;
      else if (tick_i) pend_q <= 1'b0;

      if (tick_i && !first_ld_i && nxt == match_i) stat_q <= 1'b1;
      else if (clr_i)                              stat_q <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign stat_o = stat_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/sec_alarm_counter.sv
module sec_alarm_counter #(
  parameter int CW       = 32,
  parameter int PRESC_W  = 15,
  parameter int SYNC_STG = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk32_in,
  input  logic          dbg_halt,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [CW-1:0] reg_wdata,
  output logic [CW-1:0] reg_rdata,
  output logic          irq
);
  import sac_pkg::*;

  logic [CTRL_W-1:0] ctrl_q;
  logic [CW-1:0]     load_q, match_q, cnt;
  logic              mask_q, primed_q;
  logic              ref_rise, run, tick, first_ld, load_wr, clr, stat, pend;
  sac_addr_e         addr;

  assign addr     = sac_addr_e'(reg_addr);
  assign first_ld = reg_wr && addr == A_CTRL && reg_wdata[B_EN] && !primed_q;
  assign load_wr  = reg_wr && addr == A_LOAD;
  assign clr      = reg_wr && addr == A_CLR && reg_wdata[0];
  assign run      = ctrl_q[B_EN] &&
                    !(dbg_halt && ctrl_q[B_STALL] && !ctrl_q[B_CONTINUE]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      load_q   <= '0;
      match_q  <= '0;
      mask_q   <= 1'b0;
      primed_q <= 1'b0;
    end else if (reg_wr) begin
      unique case (addr)
        A_CTRL:  ctrl_q  <= reg_wdata[CTRL_W-1:0];
        A_LOAD:  load_q  <= reg_wdata;
        A_MATCH: match_q <= reg_wdata;
        A_MASK:  mask_q  <= reg_wdata[0];
        default: ;
      endcase
      if (first_ld) primed_q <= 1'b1;
    end
  end

  sac_edge_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(clk32_in), .rise_o(ref_rise)
  );

  sac_prescaler #(.W(PRESC_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .edge_i(ref_rise), .run_i(run), .tick_o(tick)
  );

  sac_count_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .first_ld_i(first_ld),
    .load_wr_i(load_wr), .load_val_i(load_q), .match_i(match_q),
    .clr_i(clr), .cnt_o(cnt), .stat_o(stat), .pend_o(pend)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (addr)
      A_CTRL:  reg_rdata[CTRL_W-1:0] = ctrl_q;
      A_LOAD:  reg_rdata = load_q;
      A_MATCH: reg_rdata = match_q;
      A_MASK:  reg_rdata[0] = mask_q;
      A_STAT:  reg_rdata[0] = stat;
      A_VALUE: reg_rdata = cnt;
      default: reg_rdata = '0;
    endcase
  end

  assign irq = stat & mask_q;
endmodule

// File: rtl/sac_checker.sv
module sac_checker #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          first_ld,
  input logic          pend,
  input logic          clr,
  input logic          stat,
  input logic          irq,
  input logic          mask_q,
  input logic          dbg_halt,
  input logic [2:0]    ctrl_q,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] match_q
);
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !pend && !first_ld) |=> cnt == $past(cnt) + 1'b1);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !first_ld) |=> $stable(cnt));

  p_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[0] |-> !tick);

  p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_halt && ctrl_q[1] && !ctrl_q[2]) |-> !tick);

  p_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat) |-> cnt == match_q);

  p_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat && mask_q));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !tick) |=> !stat);

  p_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    first_ld |=> cnt == 1);
endmodule

bind sec_alarm_counter sac_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .first_ld(first_ld), .pend(pend),
  .clr(clr), .stat(stat), .irq(irq), .mask_q(mask_q), .dbg_halt(dbg_halt),
  .ctrl_q(ctrl_q), .cnt(cnt), .match_q(match_q)
);

// File: tb/sec_alarm_counter_bench.sv
module sec_alarm_counter_bench;
  localparam int CLK_P   = 10;
  localparam int PRESC_W = 2;
  localparam int EPS     = 1 << PRESC_W;

  typedef struct packed {
    logic        ld;
    logic [31:0] lv;
    logic [7:0]  secs;
    logic [31:0] ex;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 32'd0,         8'd1, 32'd2},
    '{1'b0, 32'd0,         8'd3, 32'd5},
    '{1'b1, 32'd100,       8'd1, 32'd100},
    '{1'b1, 32'd200,       8'd2, 32'd201},
    '{1'b1, 32'hFFFF_FFFE, 8'd1, 32'hFFFF_FFFE},
    '{1'b0, 32'd0,         8'd1, 32'hFFFF_FFFF},
    '{1'b0, 32'd0,         8'd1, 32'd0},
    '{1'b0, 32'd0,         8'd2, 32'd2}
  };

  logic        clk = 0, rst_n = 0, clk32_in = 0, dbg_halt = 0, reg_wr = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, rd;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #(CLK_P/2) clk = ~clk;

  sec_alarm_counter #(.PRESC_W(PRESC_W)) u_sec_alarm_counter (
    .clk(clk), .rst_n(rst_n), .clk32_in(clk32_in), .dbg_halt(dbg_halt),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rdr(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      clk32_in = 1; repeat (3) @(negedge clk);
      clk32_in = 0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] cur;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9 reset state
    rdr(3'd6, rd); chk("R9 value", rd, 0);
    rdr(3'd0, rd); chk("R9 ctrl", rd, 0);
    rdr(3'd4, rd); chk("R9 status", rd, 0);
    chk("R9 irq", {31'd0, irq}, 0);
    // R7 no counting while disabled
    pulses(2 * EPS);
    rdr(3'd6, rd); chk("R7 disabled count", rd, 0);
    // R2 first enable loads 1
    wr(3'd0, 32'd1);
    rdr(3'd6, rd); chk("R2 first load", rd, 1);
    rdr(3'd0, rd); chk("R9 ctrl readback", rd, 1);
    // R1 R3 R4 table walk
    for (int v = 0; v < 8; v++) begin
      if (VECS[v].ld) begin
        wr(3'd1, VECS[v].lv);
        rdr(3'd1, rd); chk("R9 load readback", rd, VECS[v].lv);
      end
      pulses(int'(VECS[v].secs) * EPS);
      rdr(3'd6, rd);
      chk(VECS[v].ld ? "R3 load" : "R1 R4 count", rd, VECS[v].ex);
    end
    // R7 prescaler and count held while disabled, R2 no reload
    pulses(EPS / 2);
    wr(3'd0, 32'd0);
    pulses(EPS);
    rdr(3'd6, rd); chk("R7 hold count", rd, 2);
    wr(3'd0, 32'd1);
    rdr(3'd6, rd); chk("R2 no reload", rd, 2);
    pulses(EPS / 2);
    rdr(3'd6, rd); chk("R7 prescaler held", rd, 3);
    // R8 debug halt behaviour
    dbg_halt = 1;
    wr(3'd0, 32'd3);
    pulses(EPS);
    rdr(3'd6, rd); chk("R8 stall freezes", rd, 3);
    wr(3'd0, 32'd7);
    pulses(EPS);
    rdr(3'd6, rd); chk("R8 continue", rd, 4);
    wr(3'd0, 32'd1);
    pulses(EPS);
    rdr(3'd6, rd); chk("R8 halt ignored", rd, 5);
    dbg_halt = 0;
    wr(3'd0, 32'd3);
    pulses(EPS);
    rdr(3'd6, rd); chk("R8 stall no halt", rd, 6);
    // R5 R6 alarm
    wr(3'd5, 32'd1);
    rdr(3'd4, rd); chk("R6 clear before", rd, 0);
    rdr(3'd6, cur);
    wr(3'd2, cur + 2);
    rdr(3'd2, rd); chk("R9 match readback", rd, cur + 2);
    pulses(EPS);
    rdr(3'd4, rd); chk("R5 no early match", rd, 0);
    pulses(EPS);
    rdr(3'd4, rd); chk("R5 status set", rd, 1);
    chk("R5 irq masked", {31'd0, irq}, 0);
    wr(3'd3, 32'd1);
    @(negedge clk);
    chk("R5 irq unmasked", {31'd0, irq}, 1);
    wr(3'd5, 32'd0);
    rdr(3'd4, rd); chk("R6 zero write no effect", rd, 1);
    wr(3'd5, 32'd1);
    rdr(3'd4, rd); chk("R6 cleared", rd, 0);
    chk("R6 irq low", {31'd0, irq}, 0);
    pulses(EPS);
    rdr(3'd4, rd); chk("R5 no re-set past match", rd, 0);
    finish_run();
  end
endmodule